// File: doc/BRIEF.md
# AHB-Lite Wait-State Subordinate with Idle-Beat Handling

This block is a memory-backed AHB-Lite subordinate that holds a small word-organised register array. It treats every transfer as two pipelined stages. The address stage records the request on a rising edge where the bus ready is high. The data stage then carries out that recorded request. Reads can be stretched by a parameterised number of wait cycles, from zero to three. Writes always complete without waiting. Sub-word writes use byte lane enables.

The bus can show a BUSY, IDLE or non-selected request while an earlier read is still stalled. That request is not recorded until ready goes high, so the stalled read finishes normally and returns its data in the ready cycle. After it is recorded, a BUSY, IDLE or non-selected request gets a data phase that completes at once with an OKAY response and does not touch the array. This lets a burst master place BUSY beats between its NONSEQ and SEQ beats. The interconnect drives the global ready back to this block. In a single-subordinate system that is simply the block's own ready output.

Top module: `ahbw_slave`

## Requirements
- R1: After reset, the data stage is empty: ready_o is 1, resp_o is 0 (OKAY) and rdata_o is 0.
- R2: A read sampled with trans_i NONSEQ (2'b10) or SEQ (2'b11) holds ready_o low for exactly WAIT_RD cycles, then raises it. In that ready cycle rdata_o carries the addressed word.
- R3: Address-stage inputs are recorded only on a rising edge where ready_i is 1. A request shown only while ready_i is 0 has no effect, and the stalled read still returns its own data.
- R4: A sampled BUSY (trans_i 2'b01) gives a data phase with ready_o 1 in its first cycle. It never changes the array, even with write_i set.
- R5: A sampled IDLE (trans_i 2'b00), or any request sampled with sel_i 0, gives a zero-wait data phase and never changes the array.
- R6: A sampled write completes with ready_o 1 in its first data cycle. It stores wdata_i from that cycle into the lanes picked by the recorded address and size: size 0 selects the byte at address bits [1:0], size 1 selects the halfword at address bit 1, and size 2 selects the full word.
- R7: resp_o is 0 (OKAY) in every cycle.
- R8: rdata_o is 0 in every cycle that is not the ready cycle of a read data phase. This includes wait cycles and the data phases of BUSY and IDLE.
- R9: In a read burst made of a NONSEQ beat, BUSY beats and SEQ beats, each SEQ data phase returns the word at its own recorded address. The BUSY beats do not shift the burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Subordinate select for the current address stage |
| addr_i | input | ADDR_W | Byte address |
| trans_i | input | 2 | Transfer kind: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data, valid in the write data phase |
| ready_i | input | 1 | Global bus ready; address stage is recorded when 1 |
| ready_o | output | 1 | This subordinate's data-phase ready |
| resp_o | output | 1 | Response, always OKAY (0) |
| rdata_o | output | 32 | Read data, valid in the ready cycle of a read |

## Verification
The assertions check properties that hold on every cycle. The reset state of ready_o is checked. A recorded read must open with a stall, or with no stall when WAIT_RD is 0. A recorded BUSY, IDLE, deselected request or write must be followed at once by ready_o high. rdata_o must stay zero whenever ready_o is low. Some behaviour can only be shown by the bench's scenarios. These are the exact number of wait cycles, the value of the returned data, and the burst with two BUSY beats placed after a stretched first beat. They also cover a write that is shown only during a stall and then withdrawn, a BUSY or IDLE that carries write_i, and a sweep of sub-word lane merges, all checked against an arithmetic model of the array.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

    localparam int DATA_W    = 32;
    localparam int BUS_BYTES = DATA_W / 8;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_kind_t;

    // Only NONSEQ and SEQ move data
    function automatic logic moves_data(input logic [1:0] tr);
        return (tr == TR_NONSEQ) || (tr == TR_SEQ);
    endfunction

    // Byte lane enables for a sized access at a byte offset in the word
    function automatic logic [BUS_BYTES-1:0] lane_enables(input logic [2:0] sz,
                                                          input logic [1:0] off);
        logic [BUS_BYTES-1:0] en;
        case (sz)
            3'd0:    en = 4'b0001 << off;
            3'd1:    en = off[1] ? 4'b1100 : 4'b0011;
            default: en = 4'b1111;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/ahbw_addr_stage.sv
module ahbw_addr_stage
    import ahbw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready_i,
    input  logic              sel_i,
    input  logic [1:0]        trans_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    output phase_kind_t       kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [2:0]        size_q
);

    phase_kind_t kind_d;

    always_comb begin
        if (!sel_i || !moves_data(trans_i)) begin
            kind_d = PH_NONE;
        end else if (write_i) begin
            kind_d = PH_WRITE;
        end else begin
            kind_d = PH_READ;
        end
    end

    // The address stage advances only when the bus ready is high
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= PH_NONE;
            addr_q <= '0;
            size_q <= '0;
        end else if (ready_i) begin
            kind_q <= kind_d;
            addr_q <= addr_i;
            size_q <= size_i;
        end
    end

endmodule

// File: rtl/ahbw_wait_ctrl.sv
module ahbw_wait_ctrl #(
    parameter int WAIT_RD = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic stall_o
);

    localparam int CW = (WAIT_RD < 2) ? 1 : $clog2(WAIT_RD + 1);

    generate
        if (WAIT_RD == 0) begin : g_nowait
            logic unused_ok;
            assign unused_ok = clk ^ rst ^ load_i;
            assign stall_o   = 1'b0;
        end else begin : g_wait
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (load_i) begin
                    cnt_q <= CW'(WAIT_RD);
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign stall_o = (cnt_q != '0);
        end
    endgenerate

endmodule

// File: rtl/ahbw_regfile.sv
module ahbw_regfile
    import ahbw_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] idx_i,
    input  logic [BUS_BYTES-1:0]     be_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
                always_ff @(posedge clk) begin
                    if (rst) begin
                        mem_q[w][8*b +: 8] <= '0;
                    end else if (we_i && be_i[b] && (idx_i == w)) begin
                        mem_q[w][8*b +: 8] <= wdata_i[8*b +: 8];
                    end
                end
            end
        end
    endgenerate

    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/ahbw_slave.sv
module ahbw_slave
    import ahbw_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ADDR_W  = $clog2(DEPTH) + 2,
    parameter int WAIT_RD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        trans_i,
    input  logic              write_i,
    input  logic [2:0]        size_i,
    input  logic [31:0]       wdata_i,
    input  logic              ready_i,
    output logic              ready_o,
    output logic              resp_o,
    output logic [31:0]       rdata_o
);

    localparam int IDX_W = $clog2(DEPTH);

    phase_kind_t          dp_kind;
    logic [ADDR_W-1:0]    dp_addr;
    logic [2:0]           dp_size;
    logic                 stall;
    logic                 rd_load;
    logic                 mem_we;
    logic [IDX_W-1:0]     mem_idx;
    logic [BUS_BYTES-1:0] mem_be;
    logic [DATA_W-1:0]    mem_rdata;

    ahbw_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready_i),
        .sel_i   (sel_i),
        .trans_i (trans_i),
        .write_i (write_i),
        .addr_i  (addr_i),
        .size_i  (size_i),
        .kind_q  (dp_kind),
        .addr_q  (dp_addr),
        .size_q  (dp_size)
    );

    // A read recorded on this edge starts the wait countdown
    assign rd_load = ready_i && sel_i && moves_data(trans_i) && !write_i;

    ahbw_wait_ctrl #(.WAIT_RD(WAIT_RD)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .load_i  (rd_load),
        .stall_o (stall)
    );

    assign mem_idx = dp_addr[IDX_W+1:2];
    assign mem_be  = lane_enables(dp_size, dp_addr[1:0]);
    assign mem_we  = (dp_kind == PH_WRITE) && !stall;

    ahbw_regfile #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mem_we),
        .idx_i   (mem_idx),
        .be_i    (mem_be),
        .wdata_i (wdata_i),
        .rdata_o (mem_rdata)
    );

    assign ready_o = !stall;
    assign resp_o  = 1'b0;
    assign rdata_o = ((dp_kind == PH_READ) && !stall) ? mem_rdata : '0;

endmodule

// File: rtl/ahbw_checker.sv
module ahbw_checker #(
    parameter int WAIT_RD = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        sel_i,
    input logic [1:0]  trans_i,
    input logic        write_i,
    input logic        ready_i,
    input logic        ready_o,
    input logic [31:0] rdata_o
);

    logic rst_q;
    logic rec_read;
    logic rec_nodata;
    logic rec_write;

    always_ff @(posedge clk) rst_q <= rst;

    assign rec_read   = ready_i && sel_i && trans_i[1] && !write_i;
    assign rec_write  = ready_i && sel_i && trans_i[1] && write_i;
    assign rec_nodata = ready_i && (!sel_i || !trans_i[1]);

    // R1
    reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> ready_o);

    generate
        if (WAIT_RD > 0) begin : g_w
            // R2
            read_stall_chk: assert property (@(posedge clk) disable iff (rst)
                rec_read |=> !ready_o);
        end else begin : g_nw
            // R2
            read_nostall_chk: assert property (@(posedge clk) disable iff (rst)
                rec_read |=> ready_o);
        end
    endgenerate

    // R4
    busy_zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_i && sel_i && trans_i == 2'b01) |=> ready_o);

    // R5
    idle_zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
        rec_nodata |=> ready_o);

    // R6
    write_zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
        rec_write |=> ready_o);

    // R8
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> (rdata_o == 32'd0));

endmodule

bind ahbw_slave ahbw_checker #(.WAIT_RD(WAIT_RD)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_i),
    .trans_i (trans_i),
    .write_i (write_i),
    .ready_i (ready_i),
    .ready_o (ready_o),
    .rdata_o (rdata_o)
);

// File: tb/tb_ahbw_slave.sv
module tb_ahbw_slave;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int ADDR_W     = $clog2(DEPTH) + 2;
    localparam int WAIT       = 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sel = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        trans = 2'b00;
    logic              wr = 1'b0;
    logic [2:0]        size = 3'd2;
    logic [31:0]       wdata = '0;
    logic              ready;
    logic              resp;
    logic [31:0]       rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    ahbw_slave #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WAIT_RD(WAIT)) dut (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel),
        .addr_i  (addr),
        .trans_i (trans),
        .write_i (wr),
        .size_i  (size),
        .wdata_i (wdata),
        .ready_i (ready),
        .ready_o (ready),
        .resp_o  (resp),
        .rdata_o (rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        check("R7 resp", {31'd0, resp}, 32'd0);
    endtask

    task automatic drive(input logic s, input logic [1:0] t, input logic w,
                         input int a, input logic [2:0] z, input logic [31:0] d);
        sel = s; trans = t; wr = w; addr = ADDR_W'(a); size = z; wdata = d;
    endtask

    function automatic logic [31:0] lane_mask(input logic [2:0] z, input int a);
        logic [31:0] m;
        if (z == 3'd0)      m = 32'hFF << (8 * (a % 4));
        else if (z == 3'd1) m = 32'hFFFF << (16 * ((a / 2) % 2));
        else                m = 32'hFFFF_FFFF;
        return m;
    endfunction

    task automatic wait_ready(input string req);
        int n = 0;
        while (!ready && n < 8) begin
            check({req, " rdata zero while stalled R8"}, rdata, 32'd0);
            n++;
            tick();
        end
        check({req, " wait count"}, 32'(n), 32'(WAIT));
    endtask

    // Single write: R6 zero wait, lanes from recorded address and size
    task automatic do_write(input int a, input logic [2:0] z, input logic [31:0] d);
        logic [31:0] m;
        drive(1'b1, 2'b10, 1'b1, a, z, 32'h0BAD_0BAD);
        tick();
        check("R6 write ready", {31'd0, ready}, 32'd1);
        drive(1'b0, 2'b00, 1'b0, 0, 3'd2, d);
        tick();
        m = lane_mask(z, a);
        model[a/4] = (model[a/4] & ~m) | (d & m);
    endtask

    // Single read: R2 wait count and data in the ready cycle
    task automatic do_read(input int a, input string req);
        drive(1'b1, 2'b10, 1'b0, a, 3'd2, 32'd0);
        tick();
        drive(1'b0, 2'b00, 1'b0, 0, 3'd2, 32'd0);
        wait_ready(req);
        check(req, rdata, model[a/4]);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 ready after reset", {31'd0, ready}, 32'd1);
        check("R1 resp after reset", {31'd0, resp}, 32'd0);
        check("R1 rdata after reset", rdata, 32'd0);
        rst = 1'b0;
        tick();
        check("R1 ready out of reset", {31'd0, ready}, 32'd1);

        // R6: full word sweep
        for (int w = 0; w < DEPTH; w++)
            do_write(w * 4, 3'd2, 32'hA500_0000 ^ (32'(w) * 32'h0101_0101));
        // R6: byte lanes at every offset, halfwords at both halves
        for (int w = 0; w < 4; w++) begin
            for (int o = 0; o < 4; o++)
                do_write(w * 4 + o, 3'd0, 32'h1122_3344 + 32'(w * 16 + o));
        end
        for (int w = 4; w < 8; w++) begin
            do_write(w * 4, 3'd1, 32'hCAFE_BEEF ^ 32'(w));
            do_write(w * 4 + 2, 3'd1, 32'h5A5A_0000 | 32'(w));
        end

        // R5: deselected NONSEQ write and selected IDLE write leave array alone
        drive(1'b0, 2'b10, 1'b1, 0, 3'd2, 32'd0);
        tick();
        check("R5 deselected ready", {31'd0, ready}, 32'd1);
        drive(1'b1, 2'b00, 1'b1, 4, 3'd2, 32'hFFFF_FFFF);
        tick();
        check("R5 idle ready", {31'd0, ready}, 32'd1);
        check("R8 rdata in idle phase", rdata, 32'd0);
        drive(1'b0, 2'b00, 1'b0, 0, 3'd2, 32'hFFFF_FFFF);
        tick();
        do_read(0, "R5 deselected write ignored");
        do_read(4, "R5 idle write ignored");

        // R3: write shown only during a stall is not recorded
        drive(1'b1, 2'b10, 1'b0, 12, 3'd2, 32'd0);
        tick();
        drive(1'b1, 2'b10, 1'b1, 20, 3'd2, 32'hDEAD_DEAD);
        wait_ready("R3 stalled read");
        check("R3 stalled read data", rdata, model[3]);
        drive(1'b0, 2'b00, 1'b0, 0, 3'd2, 32'hDEAD_DEAD);
        tick();
        tick();
        do_read(20, "R3 stall-time write not recorded");

        // R2: read sweep of every word
        for (int w = 0; w < DEPTH; w++) do_read(w * 4, "R2 read sweep");

        // R9 burst with two BUSY beats after a stretched first beat
        for (int base = 8; base <= 12; base += 4) begin
            drive(1'b1, 2'b10, 1'b0, base * 4, 3'd2, 32'd0);
            tick();
            drive(1'b1, 2'b01, 1'b1, base * 4 + 4, 3'd2, 32'hDEAD_BEEF);
            wait_ready("R3 first beat under BUSY");
            check("R3 first beat data", rdata, model[base]);
            tick();
            check("R4 first BUSY ready", {31'd0, ready}, 32'd1);
            check("R8 first BUSY rdata", rdata, 32'd0);
            tick();
            check("R4 second BUSY ready", {31'd0, ready}, 32'd1);
            check("R8 second BUSY rdata", rdata, 32'd0);
            for (int b = 1; b < 4; b++) begin
                drive(1'b1, 2'b11, 1'b0, (base + b) * 4, 3'd2, 32'hDEAD_BEEF);
                tick();
                drive(1'b0, 2'b00, 1'b0, 0, 3'd2, 32'd0);
                wait_ready("R9 SEQ beat");
                check("R9 SEQ beat data (R4 no BUSY write)", rdata, model[base + b]);
            end
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule